// File: doc/BRIEF.md
# Mode-Banked Register File with Status Save

This block is the architectural register store of a processor core. It has sixteen visible registers. Indices 0 to 12 are plain data registers that every mode shares. Index 13 is the stack pointer and index 14 is the link register. Index 15 maps to the program counter, which lives outside the block. The stack pointer and the link register have physical copies per privilege bank, and the current processor mode picks which copy the read ports and the write port reach.

The block also owns the current status word. That word holds four condition flags, two interrupt mask bits and a five-bit mode field. Each exception mode has its own saved status word. An exception entry switches mode, saves the previous status and stores the supplied return address, all on one clock edge. An exception return reloads the current status from the saved word of the mode being left.

Decode, the arithmetic unit and instruction fetch sit around this block. They drive its read addresses, write requests, flag updates and exception controls.

Top module: `banked_regfile`

## Requirements
- R1: After reset the mode is supervisor (5'h13). The status word is 32'h000000D3, which means bit 7 (interrupt mask) and bit 6 (fast interrupt mask) are set and flags bits 31:28 are zero. Every register and every saved status word reads zero.
- R2: Registers 0 to 12 are one physical set, so a value written in one mode reads back unchanged in any other mode.
- R3: Registers 13 and 14 are held per bank: one copy for user (5'h10) and system (5'h1F) together, and one copy each for fast interrupt (5'h11), interrupt (5'h12), supervisor (5'h13), abort (5'h17) and undefined (5'h1B). Reads and writes reach the copy of the current mode.
- R4: Reading index 15 returns `pc_i`. A write to index 15 raises `branch_o` with `branch_addr_o` equal to the write data in the same cycle and stores nothing.
- R5: A read and a write to the same physical register in one cycle return the old value; the new value is visible after the clock edge.
- R6: A flag update loads `flag_i` (N,Z,C,V from bit 3 down) into status bits 31:28 and leaves the other status bits unchanged.
- R7: An entry request naming fast interrupt, interrupt, supervisor, abort or undefined does four things on one edge. It sets the mode to the target and sets bit 7, and it also sets bit 6 when the target is fast interrupt. It copies the previous status into the target's saved word, with any flag update of the same cycle included. It writes `exc_ret_addr_i` into the target's register 14.
- R8: An entry request naming user, system or any value outside the seven mode codes has no effect.
- R9: A return request in an exception mode loads the current status from that mode's saved word. A return in user or system mode is ignored, and so is a return whose saved word holds an illegal mode code.
- R10: `spsr_o` shows the saved word of the current exception mode, and a saved-status write replaces it. In user or system mode `spsr_o` shows the current status and a saved-status write has no effect.
- R11: When requests coincide, entry takes precedence over return. Entry's write of register 14 takes precedence over a port write to the same copy. Entry's save takes precedence over a saved-status write to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_addr_i | input | 4 | Read port A register index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 4 | Read port B register index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 4 | Write register index |
| wr_data_i | input | 32 | Write data |
| pc_i | input | 32 | Program counter value returned for index 15 |
| branch_o | output | 1 | Write to index 15 seen |
| branch_addr_o | output | 32 | Branch target carried by that write |
| flag_we_i | input | 1 | Condition flag update enable |
| flag_i | input | 4 | New N,Z,C,V flags |
| exc_req_i | input | 1 | Exception entry request |
| exc_mode_i | input | 5 | Mode code to enter |
| exc_ret_addr_i | input | 32 | Return address for the entered mode's register 14 |
| ret_req_i | input | 1 | Exception return request |
| spsr_we_i | input | 1 | Saved status write enable |
| spsr_wdata_i | input | 32 | Saved status write data |
| spsr_o | output | 32 | Saved status of current mode, or current status in user/system |
| psr_o | output | 32 | Current status word |
| mode_o | output | 5 | Current mode code |

## Verification
An exception entry can fall in the same cycle as a flag update, a port write to register 14, a saved-status write and a return request. The bench raises entry into supervisor while already in supervisor, so all of these requests aim at the same physical storage. It then checks that the new link value is the entry address and that the saved word is the prior status. It also checks that the mode stays supervisor rather than following a return. A second case pairs entry into the interrupt mode with a flag update, and the bench confirms that the new flags appear in both the current and the saved status.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int MODE_W = 5;
  localparam int BANK_W = 3;
  localparam int NBANK  = 6;
  localparam int FLAG_LSB = 28;
  localparam int IMASK_BIT = 7;
  localparam int FMASK_BIT = 6;

  localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

  localparam logic [BANK_W-1:0] BANK_SHARED = 3'd0;
  localparam logic [BANK_W-1:0] BANK_FIQ    = 3'd1;
  localparam logic [BANK_W-1:0] BANK_IRQ    = 3'd2;
  localparam logic [BANK_W-1:0] BANK_SVC    = 3'd3;
  localparam logic [BANK_W-1:0] BANK_ABT    = 3'd4;
  localparam logic [BANK_W-1:0] BANK_UND    = 3'd5;

  typedef struct packed {
    logic              legal;
    logic              excp;
    logic [BANK_W-1:0] bank;
  } mode_info_t;
endpackage

// File: rtl/bankreg_mode_dec.sv
module bankreg_mode_dec
  import bankreg_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output mode_info_t        info_o
);
  always_comb begin
    info_o = '{legal: 1'b0, excp: 1'b0, bank: BANK_SHARED};
    unique case (mode_i)
      MODE_USR, MODE_SYS: info_o.legal = 1'b1;
      MODE_FIQ: info_o = '{legal: 1'b1, excp: 1'b1, bank: BANK_FIQ};
      MODE_IRQ: info_o = '{legal: 1'b1, excp: 1'b1, bank: BANK_IRQ};
      MODE_SVC: info_o = '{legal: 1'b1, excp: 1'b1, bank: BANK_SVC};
      MODE_ABT: info_o = '{legal: 1'b1, excp: 1'b1, bank: BANK_ABT};
      MODE_UND: info_o = '{legal: 1'b1, excp: 1'b1, bank: BANK_UND};
      default: ;
    endcase
  end
endmodule

// File: rtl/bankreg_psr.sv
module bankreg_psr
  import bankreg_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flag_we_i,
  input  logic [3:0]        flag_i,
  input  logic              exc_req_i,
  input  logic [MODE_W-1:0] exc_mode_i,
  input  logic              ret_req_i,
  input  logic              spsr_we_i,
  input  logic [XLEN-1:0]   spsr_wdata_i,
  output logic [XLEN-1:0]   psr_o,
  output logic [XLEN-1:0]   spsr_o,
  output logic [BANK_W-1:0] cur_bank_o,
  output logic              lr_we_o,
  output logic [BANK_W-1:0] lr_bank_o
);
  localparam logic [XLEN-1:0] PSR_RST =
      XLEN'({1'b1, 1'b1, 1'b0, MODE_SVC});

  logic [XLEN-1:0] psr_q, psr_d, flagged, sav;
  logic [XLEN-1:0] saved_q [NBANK];
  mode_info_t cur_info, tgt_info, sav_info;
  logic do_entry, do_ret;

  bankreg_mode_dec u_cur (.mode_i(psr_q[MODE_W-1:0]), .info_o(cur_info));
  bankreg_mode_dec u_tgt (.mode_i(exc_mode_i),        .info_o(tgt_info));
  bankreg_mode_dec u_sav (.mode_i(sav[MODE_W-1:0]),   .info_o(sav_info));

  assign sav      = saved_q[cur_info.bank];
  assign do_entry = exc_req_i && tgt_info.excp;
  assign do_ret   = ret_req_i && !do_entry && cur_info.excp && sav_info.legal;

  always_comb begin
    flagged = psr_q;
    if (flag_we_i) flagged[FLAG_LSB +: 4] = flag_i;
  end

  always_comb begin
    psr_d = flagged;
    if (do_entry) begin
      psr_d[MODE_W-1:0] = exc_mode_i;
      psr_d[IMASK_BIT]  = 1'b1;
      psr_d[FMASK_BIT]  = flagged[FMASK_BIT] | (tgt_info.bank == BANK_FIQ);
    end else if (do_ret) begin
      psr_d = sav;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psr_q <= PSR_RST;
      for (int b = 0; b < NBANK; b++) saved_q[b] <= '0;
    end else begin
      psr_q <= psr_d;
      if (spsr_we_i && cur_info.excp) saved_q[cur_info.bank] <= spsr_wdata_i;
      if (do_entry) saved_q[tgt_info.bank] <= flagged;  // entry save wins
    end
  end

  assign psr_o      = psr_q;
  assign spsr_o     = cur_info.excp ? sav : psr_q;
  assign cur_bank_o = cur_info.bank;
  assign lr_we_o    = do_entry;
  assign lr_bank_o  = tgt_info.bank;

  a_r1_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_info.legal);
  a_r7_entry_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_entry |=> psr_q[MODE_W-1:0] == $past(exc_mode_i) && psr_q[IMASK_BIT]);
  a_r7_entry_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_entry |=> saved_q[$past(tgt_info.bank)] == $past(flagged));
  a_r8_illegal_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i && !tgt_info.excp && !ret_req_i && !flag_we_i) |=> $stable(psr_q));
  a_r9_return_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_ret |=> psr_q == $past(sav));
  a_r10_shared_spsr_noeffect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spsr_we_i && !cur_info.excp) |=> $stable(saved_q[BANK_SHARED]));
endmodule

// File: rtl/bankreg_gpr.sv
module bankreg_gpr
  import bankreg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] cur_bank_i,
  input  logic [AW-1:0]     rd_a_addr_i,
  output logic [XLEN-1:0]   rd_a_data_o,
  input  logic [AW-1:0]     rd_b_addr_i,
  output logic [XLEN-1:0]   rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [XLEN-1:0]   wr_data_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              lr_we_i,
  input  logic [BANK_W-1:0] lr_bank_i,
  input  logic [XLEN-1:0]   lr_data_i
);
  localparam int NSHARED = NREG - 3;
  localparam logic [AW-1:0] SP_IDX = AW'(NREG - 3);
  localparam logic [AW-1:0] LR_IDX = AW'(NREG - 2);
  localparam logic [AW-1:0] PC_IDX = AW'(NREG - 1);

  logic [XLEN-1:0] shared_q [NSHARED];
  logic [XLEN-1:0] sp_q [NBANK];
  logic [XLEN-1:0] lr_q [NBANK];
  logic [AW-1:0]   raddr [2];
  logic [XLEN-1:0] rdata [2];

  assign raddr[0]    = rd_a_addr_i;
  assign raddr[1]    = rd_b_addr_i;
  assign rd_a_data_o = rdata[0];
  assign rd_b_data_o = rdata[1];

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_comb begin
      if (raddr[p] == PC_IDX)      rdata[p] = pc_i;
      else if (raddr[p] == LR_IDX) rdata[p] = lr_q[cur_bank_i];
      else if (raddr[p] == SP_IDX) rdata[p] = sp_q[cur_bank_i];
      else                         rdata[p] = shared_q[raddr[p]];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NSHARED; r++) shared_q[r] <= '0;
      for (int b = 0; b < NBANK; b++) begin
        sp_q[b] <= '0;
        lr_q[b] <= '0;
      end
    end else begin
      if (wr_en_i && wr_addr_i < SP_IDX) shared_q[wr_addr_i] <= wr_data_i;
      if (wr_en_i && wr_addr_i == SP_IDX) sp_q[cur_bank_i] <= wr_data_i;
      if (wr_en_i && wr_addr_i == LR_IDX) lr_q[cur_bank_i] <= wr_data_i;
      if (lr_we_i) lr_q[lr_bank_i] <= lr_data_i;  // entry wins
    end
  end

  a_r3_sp_bank_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == SP_IDX) |=> sp_q[$past(cur_bank_i)] == $past(wr_data_i));
  a_r11_entry_lr_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_we_i |=> lr_q[$past(lr_bank_i)] == $past(lr_data_i));
  a_r4_pc_write_keeps_lr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == PC_IDX && !lr_we_i) |=> $stable(lr_q[cur_bank_i]));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankreg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     rd_a_addr_i,
  output logic [XLEN-1:0]   rd_a_data_o,
  input  logic [AW-1:0]     rd_b_addr_i,
  output logic [XLEN-1:0]   rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [XLEN-1:0]   wr_data_i,
  input  logic [XLEN-1:0]   pc_i,
  output logic              branch_o,
  output logic [XLEN-1:0]   branch_addr_o,
  input  logic              flag_we_i,
  input  logic [3:0]        flag_i,
  input  logic              exc_req_i,
  input  logic [MODE_W-1:0] exc_mode_i,
  input  logic [XLEN-1:0]   exc_ret_addr_i,
  input  logic              ret_req_i,
  input  logic              spsr_we_i,
  input  logic [XLEN-1:0]   spsr_wdata_i,
  output logic [XLEN-1:0]   spsr_o,
  output logic [XLEN-1:0]   psr_o,
  output logic [MODE_W-1:0] mode_o
);
  localparam logic [AW-1:0] PC_IDX = AW'(NREG - 1);

  logic [BANK_W-1:0] cur_bank, lr_bank;
  logic              lr_we;

  bankreg_psr #(.XLEN(XLEN)) u_psr (
    .clk_i, .rst_ni,
    .flag_we_i, .flag_i,
    .exc_req_i, .exc_mode_i, .ret_req_i,
    .spsr_we_i, .spsr_wdata_i,
    .psr_o, .spsr_o,
    .cur_bank_o(cur_bank),
    .lr_we_o(lr_we),
    .lr_bank_o(lr_bank)
  );

  bankreg_gpr #(.XLEN(XLEN), .NREG(NREG)) u_gpr (
    .clk_i, .rst_ni,
    .cur_bank_i(cur_bank),
    .rd_a_addr_i, .rd_a_data_o,
    .rd_b_addr_i, .rd_b_data_o,
    .wr_en_i, .wr_addr_i, .wr_data_i,
    .pc_i,
    .lr_we_i(lr_we),
    .lr_bank_i(lr_bank),
    .lr_data_i(exc_ret_addr_i)
  );

  assign mode_o        = psr_o[MODE_W-1:0];
  assign branch_o      = wr_en_i && (wr_addr_i == PC_IDX);
  assign branch_addr_o = wr_data_i;
endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  rd_a_addr_i = '0, rd_b_addr_i = '0, wr_addr_i = '0;
  logic [31:0] rd_a_data_o, rd_b_data_o, wr_data_i = '0, pc_i = '0;
  logic        wr_en_i = 1'b0, branch_o, flag_we_i = 1'b0;
  logic [31:0] branch_addr_o, exc_ret_addr_i = '0, spsr_wdata_i = '0;
  logic [31:0] spsr_o, psr_o;
  logic [3:0]  flag_i = '0;
  logic        exc_req_i = 1'b0, ret_req_i = 1'b0, spsr_we_i = 1'b0;
  logic [4:0]  exc_mode_i = '0, mode_o;

  int n_chk = 0, n_err = 0;

  always #4 clk_i = ~clk_i;

  banked_regfile u0 (.*);

  // {addr, data}: written in supervisor mode, read back on both ports
  localparam logic [35:0] WR_TAB [8] = '{
    {4'd0,  32'h1111_1111}, {4'd5,  32'h0000_0055},
    {4'd12, 32'h0000_C0C0}, {4'd13, 32'h0000_5A13},
    {4'd14, 32'h0000_5A14}, {4'd7,  32'h0000_0077},
    {4'd1,  32'h0000_0001}, {4'd9,  32'h0000_0099}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en_i = 0; flag_we_i = 0; exc_req_i = 0; ret_req_i = 0; spsr_we_i = 0;
  endtask

  task automatic tick();
    @(posedge clk_i); #1; idle(); #1;
  endtask

  task automatic rd(input logic [3:0] a, input logic [3:0] b);
    rd_a_addr_i = a; rd_b_addr_i = b; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1; #1;
    // R1 reset state
    rd(4'd0, 4'd14);
    chk("R1 mode", {27'd0, mode_o}, 32'h13);
    chk("R1 psr", psr_o, 32'h0000_00D3);
    chk("R1 r0", rd_a_data_o, 32'h0);
    chk("R1 r14", rd_b_data_o, 32'h0);
    chk("R1 spsr", spsr_o, 32'h0);

    // R2/R3 table walk in supervisor mode
    for (int i = 0; i < 8; i++) begin
      wr_en_i = 1; wr_addr_i = WR_TAB[i][35:32]; wr_data_i = WR_TAB[i][31:0];
      tick();
      rd(WR_TAB[i][35:32], WR_TAB[i][35:32]);
      chk("R2 table port A", rd_a_data_o, WR_TAB[i][31:0]);
      chk("R2 table port B", rd_b_data_o, WR_TAB[i][31:0]);
    end

    // R6 flag update
    flag_we_i = 1; flag_i = 4'b1010; tick();
    chk("R6 flags", psr_o, 32'hA000_00D3);

    // R4 index 15
    pc_i = 32'h8000; rd(4'd15, 4'd14);
    chk("R4 pc read", rd_a_data_o, 32'h8000);
    wr_en_i = 1; wr_addr_i = 4'd15; wr_data_i = 32'h400; #1;
    chk("R4 branch", {31'd0, branch_o}, 32'd1);
    chk("R4 branch addr", branch_addr_o, 32'h400);
    tick(); rd(4'd13, 4'd14);
    chk("R4 sp kept", rd_a_data_o, 32'h5A13);
    chk("R4 lr kept", rd_b_data_o, 32'h5A14);
    chk("R4 no branch idle", {31'd0, branch_o}, 32'd0);

    // R5 read during write
    rd(4'd5, 4'd5);
    wr_en_i = 1; wr_addr_i = 4'd5; wr_data_i = 32'hABC; #1;
    chk("R5 old value", rd_a_data_o, 32'h55);
    tick();
    chk("R5 new value", rd_a_data_o, 32'hABC);

    // R10 saved status in supervisor
    chk("R10 svc spsr reset", spsr_o, 32'h0);
    spsr_we_i = 1; spsr_wdata_i = 32'h10; tick();
    chk("R10 svc spsr write", spsr_o, 32'h10);

    // R9 return to user
    ret_req_i = 1; tick();
    chk("R9 return user", psr_o, 32'h10);
    rd(4'd13, 4'd0);
    chk("R3 user sp", rd_a_data_o, 32'h0);
    chk("R2 shared r0", rd_b_data_o, 32'h1111_1111);
    wr_en_i = 1; wr_addr_i = 4'd13; wr_data_i = 32'hAAAA; tick();

    // R10 user mode saved status
    chk("R10 user spsr view", spsr_o, 32'h10);
    spsr_we_i = 1; spsr_wdata_i = 32'hF000_001B; tick();
    chk("R10 user spsr write ignored", spsr_o, 32'h10);
    ret_req_i = 1; tick();
    chk("R9 user return ignored", psr_o, 32'h10);

    // R8 illegal targets
    exc_req_i = 1; exc_mode_i = 5'h1F; tick();
    chk("R8 system target", psr_o, 32'h10);
    exc_req_i = 1; exc_mode_i = 5'h0A; tick();
    chk("R8 bad code", psr_o, 32'h10);

    // R7 entry to interrupt with flag update
    exc_req_i = 1; exc_mode_i = 5'h12; exc_ret_addr_i = 32'h1234;
    flag_we_i = 1; flag_i = 4'b0101; tick();
    rd(4'd13, 4'd14);
    chk("R7 irq psr", psr_o, 32'h5000_0092);
    chk("R7 irq saved", spsr_o, 32'h5000_0010);
    chk("R7 irq lr", rd_b_data_o, 32'h1234);
    chk("R3 irq sp", rd_a_data_o, 32'h0);

    // R7 fast interrupt from interrupt
    exc_req_i = 1; exc_mode_i = 5'h11; exc_ret_addr_i = 32'h2000; tick();
    chk("R7 fiq psr", psr_o, 32'h5000_00D1);
    chk("R7 fiq saved", spsr_o, 32'h5000_0092);
    chk("R7 fiq lr", rd_b_data_o, 32'h2000);

    ret_req_i = 1; tick();
    chk("R9 back to irq", psr_o, 32'h5000_0092);
    chk("R3 irq lr kept", rd_b_data_o, 32'h1234);
    ret_req_i = 1; tick();
    chk("R9 back to user", psr_o, 32'h5000_0010);
    chk("R3 user sp kept", rd_a_data_o, 32'hAAAA);

    // R7 supervisor entry, banked sp returns
    exc_req_i = 1; exc_mode_i = 5'h13; exc_ret_addr_i = 32'h3000; tick();
    chk("R7 svc psr", psr_o, 32'h5000_0093);
    chk("R3 svc sp kept", rd_a_data_o, 32'h5A13);
    chk("R7 svc lr", rd_b_data_o, 32'h3000);

    // R11 coinciding requests on the same storage
    exc_req_i = 1; exc_mode_i = 5'h13; exc_ret_addr_i = 32'h4000;
    wr_en_i = 1; wr_addr_i = 4'd14; wr_data_i = 32'hDEAD;
    spsr_we_i = 1; spsr_wdata_i = 32'h1B; ret_req_i = 1; tick();
    chk("R11 mode stays", psr_o, 32'h5000_0093);
    chk("R11 saved from entry", spsr_o, 32'h5000_0093);
    chk("R11 lr from entry", rd_b_data_o, 32'h4000);

    // R9 illegal saved mode
    spsr_we_i = 1; spsr_wdata_i = 32'h05; tick();
    ret_req_i = 1; tick();
    chk("R9 illegal saved ignored", psr_o, 32'h5000_0093);

    // R3 system shares user copy
    spsr_we_i = 1; spsr_wdata_i = 32'h1F; tick();
    ret_req_i = 1; tick();
    chk("R9 return system", psr_o, 32'h1F);
    chk("R3 system sp", rd_a_data_o, 32'hAAAA);
    chk("R10 system spsr view", spsr_o, 32'h1F);

    // R7 undefined entry from system
    exc_req_i = 1; exc_mode_i = 5'h1B; exc_ret_addr_i = 32'h5000; tick();
    chk("R7 und psr", psr_o, 32'h0000_009B);
    chk("R7 und saved", spsr_o, 32'h1F);
    chk("R7 und lr", rd_b_data_o, 32'h5000);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule